// File: doc/BRIEF.md
# I2C Slave Bus-Condition and Status Tracker

This block keeps the status byte of an I2C slave port. It watches the SCL and SDA lines for START and STOP conditions. It also takes single-cycle strobes from the byte engine that sits next to it: address matched, byte finished, acknowledge seen, transmission started. A software-side strobe for "address register written" and one for "receive buffer read" are also inputs. From these it keeps an eight-bit status word. That word reports:

- which bus condition came last;
- whether the last byte was an address or data;
- the read/write direction taken at the address match;
- whether the second part of a ten-bit address must be loaded;
- whether the data buffer is occupied.

Raw SCL and SDA pass through an N-flop synchronizer before edge detection. Byte shifting, clock stretching and acknowledge generation belong to other blocks.

Top module: `i2c_status_tracker`

## Requirements
- R1: After reset the status byte is 0x00. The field layout from bit 7 down to bit 0 is: two reserved bits that always read 0, data-or-address (bit 5), stop-seen (bit 4), start-seen (bit 3), direction (bit 2), address-update (bit 1), buffer-full (bit 0).
- R2: A START is SDA going from 1 to 0 while the synchronized SCL is 1 both before and after the change. It sets bit 3 and clears bit 4. The status changes SYNC_STAGES+1 clock edges after the raw SDA change is first sampled.
- R3: A STOP is SDA going from 0 to 1 while the synchronized SCL is 1 both before and after the change. It sets bit 4 and clears bit 3, with the same latency as R2.
- R4: While `enable` is 0 the whole status byte is forced to 0, and strobes or bus conditions during that time leave no trace once `enable` returns to 1.
- R5: On `byte_done`, bit 5 takes the value of `byte_is_data` (1 = data, 0 = address). Otherwise bit 5 holds.
- R6: On `addr_match`, bit 2 takes `addr_rw` (1 = read, 0 = write) on the next edge.
- R7: Bit 2 returns to 0 on a START, a STOP or an `ack` strobe. If `addr_match` arrives in the same cycle as one of these, the match wins.
- R8: `addr_match` with `addr_ten_pending` = 1 sets bit 1. `addr_reg_wr` clears it. If both arrive together, the set wins.
- R9: In receive mode, `byte_done` sets bit 0 and `buf_rd` clears it. If both arrive together, the set wins.
- R10: `tx_start` sets bit 0 and enters transmit mode. There, `byte_done` clears bit 0 and `buf_rd` has no effect. A START or STOP returns the block to receive mode.
- R11: SDA edges while SCL is low change neither bit 3 nor bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; 0 clears all status |
| scl_raw | input | 1 | SCL line, asynchronous |
| sda_raw | input | 1 | SDA line, asynchronous |
| addr_match | input | 1 | Strobe: incoming address matched |
| addr_rw | input | 1 | Direction bit qualified by addr_match |
| addr_ten_pending | input | 1 | Qualified by addr_match: ten-bit address needs its next part |
| byte_done | input | 1 | Strobe: a byte finished on the bus |
| byte_is_data | input | 1 | Qualified by byte_done: 1 data, 0 address |
| ack | input | 1 | Strobe: acknowledge bit seen |
| tx_start | input | 1 | Strobe: transmit byte loaded |
| addr_reg_wr | input | 1 | Strobe: software wrote the address register |
| buf_rd | input | 1 | Strobe: software read the receive buffer |
| status | output | 8 | Status byte |

## Verification
The bench builds the tracker with a three-stage synchronizer instead of the default two. This checks that the START/STOP latency follows the parameter and is not fixed at one value. With the deeper pipeline, SDA pulses shorter than the pipeline and SCL-low SDA toggling are also reached, together with same-cycle collisions of set and clear strobes.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    localparam int STATUS_W = 8;

    // Bit positions of the status byte
    localparam int BIT_DA    = 5;
    localparam int BIT_STOP  = 4;
    localparam int BIT_START = 3;
    localparam int BIT_RW    = 2;
    localparam int BIT_UA    = 1;
    localparam int BIT_BF    = 0;

    typedef struct packed {
        logic da;
        logic stop_seen;
        logic start_seen;
        logic rw;
        logic ua;
        logic bf;
        logic xmit;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{default: 1'b0};

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/i2cst_cond_detect.sv
module i2cst_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  scl_stable_hi;

    always_comb begin
        hist_d          = hist_q;
        hist_d.scl_prev = scl_s;
        hist_d.sda_prev = sda_s;
        scl_stable_hi   = scl_s & hist_q.scl_prev;
        start_o         = scl_stable_hi &  hist_q.sda_prev & ~sda_s;
        stop_o          = scl_stable_hi & ~hist_q.sda_prev &  sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '{scl_prev: 1'b1, sda_prev: 1'b1};
        else        hist_q <= hist_d;
    end

    // R11
    cond_needs_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> (scl_s && hist_q.scl_prev));

    // R2
    start_is_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !hist_q.sda_prev);

    // R3
    stop_is_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> hist_q.sda_prev);

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

endmodule

// File: rtl/i2cst_status_reg.sv
module i2cst_status_reg
    import i2cst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   start_evt,
    input  logic   stop_evt,
    input  logic   addr_match,
    input  logic   addr_rw,
    input  logic   addr_ten_pending,
    input  logic   byte_done,
    input  logic   byte_is_data,
    input  logic   ack,
    input  logic   tx_start,
    input  logic   addr_reg_wr,
    input  logic   buf_rd,
    output flags_t flags_o
);

    flags_t flags_d, flags_q;
    logic   bus_cond;

    always_comb begin
        flags_d  = flags_q;
        bus_cond = start_evt | stop_evt;

        if (!enable) begin
            flags_d = FLAGS_RESET;
        end else begin
            // Bus condition flags: each one clears the other
            if (start_evt) begin
                flags_d.start_seen = 1'b1;
                flags_d.stop_seen  = 1'b0;
            end
            if (stop_evt) begin
                flags_d.stop_seen  = 1'b1;
                flags_d.start_seen = 1'b0;
            end

            // Data or address of the last byte
            if (byte_done) flags_d.da = byte_is_data;

            // Direction: valid from match until the next START, STOP or ACK
            if (bus_cond || ack) flags_d.rw = 1'b0;
            if (addr_match)      flags_d.rw = addr_rw;

            // Ten-bit address update request
            if (addr_reg_wr)                     flags_d.ua = 1'b0;
            if (addr_match && addr_ten_pending)  flags_d.ua = 1'b1;

            // Buffer-full and transfer direction
            if (bus_cond) flags_d.xmit = 1'b0;
            if (flags_q.xmit) begin
                if (byte_done) flags_d.bf = 1'b0;
            end else begin
                if (buf_rd)    flags_d.bf = 1'b0;
                if (byte_done) flags_d.bf = 1'b1;
            end
            if (tx_start) begin
                flags_d.bf   = 1'b1;
                flags_d.xmit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RESET;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R2
    start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_evt) |=> (flags_q.start_seen && !flags_q.stop_seen));

    // R3
    stop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_evt) |=> (flags_q.stop_seen && !flags_q.start_seen));

    // R4
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (flags_q == FLAGS_RESET));

    // R6
    rw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && addr_match) |=> (flags_q.rw == $past(addr_rw)));

    // R7
    rw_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !addr_match && (start_evt || stop_evt || ack)) |=> !flags_q.rw);

    // R8
    ua_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_reg_wr && !(addr_match && addr_ten_pending)) |=> !flags_q.ua);

    // R9
    rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !flags_q.xmit && byte_done) |=> flags_q.bf);

    // R10
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tx_start) |=> (flags_q.bf && flags_q.xmit));

endmodule

// File: rtl/i2c_status_tracker.sv
module i2c_status_tracker
    import i2cst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                scl_raw,
    input  logic                sda_raw,
    input  logic                addr_match,
    input  logic                addr_rw,
    input  logic                addr_ten_pending,
    input  logic                byte_done,
    input  logic                byte_is_data,
    input  logic                ack,
    input  logic                tx_start,
    input  logic                addr_reg_wr,
    input  logic                buf_rd,
    output logic [STATUS_W-1:0] status
);

    logic   scl_s, sda_s;
    logic   start_evt, stop_evt;
    flags_t flags;

    i2cst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_raw), .q(scl_s)
    );

    i2cst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_raw), .q(sda_s)
    );

    i2cst_cond_detect u_detect (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_o(start_evt), .stop_o(stop_evt)
    );

    i2cst_status_reg u_status (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .addr_match(addr_match), .addr_rw(addr_rw),
        .addr_ten_pending(addr_ten_pending),
        .byte_done(byte_done), .byte_is_data(byte_is_data),
        .ack(ack), .tx_start(tx_start),
        .addr_reg_wr(addr_reg_wr), .buf_rd(buf_rd),
        .flags_o(flags)
    );

    always_comb begin
        status            = '0;
        status[BIT_DA]    = flags.da;
        status[BIT_STOP]  = flags.stop_seen;
        status[BIT_START] = flags.start_seen;
        status[BIT_RW]    = flags.rw;
        status[BIT_UA]    = flags.ua;
        status[BIT_BF]    = flags.bf;
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:6] == 2'b00);

    // R2
    start_stop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[4:3]));

endmodule

// File: tb/tb_i2c_status_tracker.sv
`timescale 1ns/1ps
module tb_i2c_status_tracker;

    localparam int SYNC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic scl_raw = 1'b1, sda_raw = 1'b1;
    logic addr_match = 0, addr_rw = 0, addr_ten_pending = 0;
    logic byte_done = 0, byte_is_data = 0, ack = 0, tx_start = 0;
    logic addr_reg_wr = 0, buf_rd = 0;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    i2c_status_tracker #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .scl_raw(scl_raw), .sda_raw(sda_raw),
        .addr_match(addr_match), .addr_rw(addr_rw),
        .addr_ten_pending(addr_ten_pending),
        .byte_done(byte_done), .byte_is_data(byte_is_data),
        .ack(ack), .tx_start(tx_start),
        .addr_reg_wr(addr_reg_wr), .buf_rd(buf_rd),
        .status(status)
    );

    // ---------------- reference model ----------------
    bit m_da, m_p, m_s, m_rw, m_ua, m_bf, m_tx;
    bit sda_pipe[$];
    bit scl_pipe[$];
    bit sda_old, scl_old;

    function automatic logic [7:0] model_word();
        return {2'b00, m_da, m_p, m_s, m_rw, m_ua, m_bf};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_da, m_p, m_s, m_rw, m_ua, m_bf, m_tx} = '0;
            sda_pipe.delete(); scl_pipe.delete();
            for (int i = 0; i < SYNC; i++) begin
                sda_pipe.push_back(1'b1); scl_pipe.push_back(1'b1);
            end
            sda_old = 1'b1; scl_old = 1'b1;
        end else begin
            bit sc, sd, st, sp;
            sc = scl_pipe[SYNC-1];
            sd = sda_pipe[SYNC-1];
            st = sc && scl_old && sda_old && !sd;
            sp = sc && scl_old && !sda_old && sd;
            if (!enable) begin
                {m_da, m_p, m_s, m_rw, m_ua, m_bf, m_tx} = '0;
            end else begin
                bit tx_before;
                tx_before = m_tx;
                if (st) begin m_s = 1; m_p = 0; end
                if (sp) begin m_p = 1; m_s = 0; end
                if (byte_done) m_da = byte_is_data;
                if (addr_match) m_rw = addr_rw;
                else if (st || sp || ack) m_rw = 0;
                if (addr_match && addr_ten_pending) m_ua = 1;
                else if (addr_reg_wr) m_ua = 0;
                if (st || sp) m_tx = 0;
                if (tx_start) begin
                    m_bf = 1; m_tx = 1;
                end else if (tx_before) begin
                    if (byte_done) m_bf = 0;
                end else if (byte_done) m_bf = 1;
                else if (buf_rd) m_bf = 0;
            end
            scl_old = sc; sda_old = sd;
            void'(sda_pipe.pop_back()); void'(scl_pipe.pop_back());
            sda_pipe.push_front(sda_raw); scl_pipe.push_front(scl_raw);
        end
    end

    function automatic string bit_req(int b);
        case (b)
            5: return "R5";
            4: return "R3";
            3: return "R2";
            2: return "R6";
            1: return "R8";
            0: return "R9";
            default: return "R1";
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp;
            exp = model_word();
            checks++;
            if (status !== exp) begin
                failures++;
                for (int b = 7; b >= 0; b--)
                    if (status[b] !== exp[b])
                        $display("FAIL %s bit%0d status=%02h expected=%02h at %0t",
                                 bit_req(b), b, status, exp, $time);
            end
        end
    end

    // Named checks against values taken straight from the requirements
    task automatic expect_bits(string req, logic [7:0] mask, logic [7:0] val);
        checks++;
        if ((status & mask) !== val) begin
            failures++;
            $display("FAIL %s status&%02h=%02h expected=%02h", req, mask, status & mask, val);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; tick(1); sig = 1'b0;
    endtask

    localparam int SETTLE = SYNC + 3;

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_bits("R1", 8'hFF, 8'h00);
        enable = 1'b1;
        tick(2);

        // R2 START and its latency
        sda_raw = 1'b0;
        tick(SYNC);
        expect_bits("R2", 8'h18, 8'h00);
        tick(1);
        expect_bits("R2", 8'h18, 8'h08);
        scl_raw = 1'b0; tick(2);

        // R11: SDA toggling while SCL low
        for (int i = 0; i < 6; i++) begin sda_raw = ~sda_raw; tick(2); end
        tick(SETTLE);
        expect_bits("R11", 8'h18, 8'h08);

        // R6 read address, R5 address byte
        addr_rw = 1'b1; pulse(addr_match); addr_rw = 1'b0;
        expect_bits("R6", 8'h04, 8'h04);
        byte_is_data = 1'b0; pulse(byte_done);
        expect_bits("R5", 8'h20, 8'h00);
        // R7 ack closes window
        pulse(ack);
        expect_bits("R7", 8'h04, 8'h00);

        // R7: match and ack together, match wins
        addr_match = 1; addr_rw = 1; ack = 1; tick(1);
        addr_match = 0; addr_rw = 0; ack = 0;
        expect_bits("R7", 8'h04, 8'h04);

        // R10 transmit
        pulse(tx_start);
        expect_bits("R10", 8'h01, 8'h01);
        pulse(buf_rd);
        expect_bits("R10", 8'h01, 8'h01);
        byte_is_data = 1; pulse(byte_done);
        expect_bits("R10", 8'h21, 8'h20);

        // R3 STOP: SDA low, SCL high, then SDA high
        sda_raw = 0; tick(2); scl_raw = 1; tick(SETTLE);
        sda_raw = 1; tick(SETTLE);
        expect_bits("R3", 8'h1C, 8'h10);

        // New START returns to receive mode; R9 receive
        sda_raw = 0; tick(SETTLE); scl_raw = 0; tick(2);
        expect_bits("R2", 8'h18, 8'h08);
        byte_is_data = 1; pulse(byte_done);
        expect_bits("R9", 8'h21, 8'h21);
        pulse(buf_rd);
        expect_bits("R9", 8'h01, 8'h00);
        byte_done = 1; buf_rd = 1; tick(1); byte_done = 0; buf_rd = 0;
        expect_bits("R9", 8'h01, 8'h01);
        pulse(buf_rd);

        // R8 ten-bit update
        addr_ten_pending = 1; pulse(addr_match); addr_ten_pending = 0;
        expect_bits("R8", 8'h02, 8'h02);
        pulse(addr_reg_wr);
        expect_bits("R8", 8'h02, 8'h00);
        addr_ten_pending = 1; addr_match = 1; addr_reg_wr = 1; tick(1);
        addr_ten_pending = 0; addr_match = 0; addr_reg_wr = 0;
        expect_bits("R8", 8'h02, 8'h02);

        // R4 disable clears and ignores
        enable = 0; tick(1);
        expect_bits("R4", 8'hFF, 8'h00);
        pulse(byte_done); pulse(tx_start);
        addr_ten_pending = 1; addr_rw = 1; pulse(addr_match);
        addr_ten_pending = 0; addr_rw = 0;
        scl_raw = 1; tick(SETTLE); sda_raw = 1; tick(SETTLE);
        enable = 1; tick(2);
        expect_bits("R4", 8'hFF, 8'h00);

        // Short SDA glitch below pipeline depth with SCL high: START then STOP
        sda_raw = 0; tick(1); sda_raw = 1; tick(SETTLE);
        expect_bits("R3", 8'h18, 8'h10);

        tick(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule